// File: doc/BRIEF.md
# Addressing-Mode Bus Sequencer

This block produces, cycle by cycle, the memory accesses that an 8-bit processor with a 16-bit address bus makes while it carries out one instruction. Each cycle carries exactly one bus access, either a read or a write. The sequence begins with the opcode fetch. It then fetches the operand bytes, does the pointer and index arithmetic, and ends with the data access. The block keeps its own program counter.

During the opcode fetch cycle, a decoder outside the block presents the addressing mode, the access kind (read, write or read-modify-write) and the modify operation. These inputs are latched at the end of that cycle. The index registers and the accumulator come from the register file and are held stable for the whole instruction. The `done_o` pulse marks the final cycle of each instruction, so the cycle after it is always the next opcode fetch.

Indexed modes add the index to the low address byte first. When the address has to be fixed up, the block first issues a read at the partly formed address, with the high byte not yet corrected. Reads skip this extra cycle when the low-byte addition does not carry. Writes and read-modify-writes always spend it. A read-modify-write writes the original value back before it writes the modified one.

Top module: `amode_bus_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the block drives an opcode fetch: a read (`we_o`=0) at address RESET_PC, with `done_o` low.
- R2: Each cycle performs one access, a write when `we_o`=1 and a read otherwise. `done_o` is high only in the last cycle of an instruction. The next cycle reads the opcode at the program counter, which has advanced by one for each opcode and operand byte.
- R3: Mode code 0 (implied) takes 2 cycles: the fetch, then a read at PC+1 that does not advance the PC. Mode codes 9 to 15 behave the same way.
- R4: Zero page (code 1) reads the operand byte and accesses {0x00, operand}. The zero-page indexed modes (code 2 uses X, code 3 uses Y) first issue a dummy read at {0x00, operand} and then access {0x00, (operand+index) mod 256}. A read or a store takes 3 cycles for code 1 and 4 cycles for codes 2 and 3.
- R5: Absolute (code 4) fetches the low address byte, then the high address byte, then accesses that address. A read or a store takes 4 cycles.
- R6: For an absolute indexed read (code 5 uses X, code 6 uses Y), the fourth cycle reads {high, (low+index) mod 256}. If the low-byte sum does not carry, that read ends the instruction in 4 cycles. If it carries, the read is a dummy and a fifth cycle reads at base+index.
- R7: For absolute indexed writes and read-modify-writes, the dummy read at the uncorrected address always happens, followed by the access at base+index. A store takes 5 cycles whether or not a page is crossed.
- R8: (zp,X) (code 7) issues a dummy read at {0x00, ptr}. It reads the low byte at {0x00, (ptr+X) mod 256} and the high byte at {0x00, (ptr+X+1) mod 256}, then accesses {high, low}. A store takes 6 cycles.
- R9: (zp),Y (code 8) reads the low byte at {0x00, ptr} and the high byte at {0x00, (ptr+1) mod 256}, then follows the R6/R7 fix-up rule with Y. A read takes 5 cycles, or 6 when a page is crossed. A store always takes 6.
- R10: Access kind is coded 0 for read, 1 for write and 2 for read-modify-write; code 3 acts as a read. A write drives the accumulator on `wdata_o` in its final cycle.
- R11: A read-modify-write reads the operand at the effective address, writes the unchanged value back to it, then writes the modified value there in the final cycle. It takes 5 cycles for zero page, 6 for zero page X, 6 for absolute and 7 for absolute X.
- R12: Modify code 0 gives (v+1) mod 256, code 1 shifts left and fills with 0, and code 2 shifts right and fills with 0. Code 3 acts as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 4 | Addressing mode code, sampled in the fetch cycle |
| kind_i | input | 2 | Access kind code, sampled in the fetch cycle |
| mop_i | input | 2 | Modify operation code, sampled in the fetch cycle |
| x_i | input | 8 | X index register |
| y_i | input | 8 | Y index register |
| acc_i | input | 8 | Accumulator, the store data |
| rdata_i | input | 8 | Memory read data for the current address |
| addr_o | output | 16 | Bus address for this cycle |
| we_o | output | 1 | 1 = write cycle, 0 = read cycle |
| wdata_o | output | 8 | Write data, meaningful when `we_o` is 1 |
| done_o | output | 1 | High in the final cycle of an instruction |

## Verification
The bench targets the page-carry boundary in absolute indexed and (zp),Y modes, each with and without a carry and with each access kind. A design that handles stores the same way as reads would finish a non-crossing store one cycle early. It also checks pointer and index wrap at the top of page zero, where a design that lets the carry spill would touch address 0x0100 or above. For read-modify-write, the bench checks the write-back of the unchanged value and the modify results at the 0xFF and bit-7 edges. A design that dropped the first write, or shifted in the wrong bit, would show a wrong write on the bus.

// File: rtl/amode_pkg.sv
`timescale 1ns/1ps
package amode_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;

    typedef enum logic [3:0] {
        AM_IMPL = 4'd0, AM_ZP = 4'd1, AM_ZPX = 4'd2, AM_ZPY = 4'd3,
        AM_ABS = 4'd4, AM_ABSX = 4'd5, AM_ABSY = 4'd6,
        AM_INDX = 4'd7, AM_INDY = 4'd8
    } amode_e;

    typedef enum logic [1:0] {AK_READ, AK_WRITE, AK_RMW, AK_SPARE} akind_e;
    typedef enum logic [1:0] {MOP_INC, MOP_ASL, MOP_LSR, MOP_SPARE} mop_e;

    // ST_FIX: index added to low byte; final read or dummy read.
    // ST_KEEP / ST_MOD: the two write-backs of a read-modify-write.
    typedef enum logic [3:0] {
        ST_FETCH, ST_IMPL, ST_OPLO, ST_OPHI, ST_ZIDX,
        ST_PLO, ST_PHI, ST_FIX, ST_EFF, ST_KEEP, ST_MOD
    } state_e;

    typedef struct packed {
        amode_e mode;
        akind_e kind;
        mop_e   op;
    } ictl_t;

    function automatic logic mode_uses_y(amode_e m);
        return (m == AM_ZPY) || (m == AM_ABSY) || (m == AM_INDY);
    endfunction

    function automatic logic [DW-1:0] apply_mop(mop_e op, logic [DW-1:0] v);
        case (op)
            MOP_ASL: return {v[DW-2:0], 1'b0};
            MOP_LSR: return {1'b0, v[DW-1:1]};
            default: return v + 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/amode_fsm.sv
`timescale 1ns/1ps
module amode_fsm
    import amode_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ictl_t  ctl_in,
    input  logic   fix_carry,
    output state_e state,
    output ictl_t  ctl,
    output logic   done
);
    state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
            ctl   <= ictl_t'('0);
        end else begin
            state <= nxt;
            if (state == ST_FETCH) ctl <= ctl_in;
        end
    end

    always_comb begin
        nxt  = state;
        done = 1'b0;
        case (state)
            ST_FETCH: nxt = (ctl_in.mode == AM_IMPL || ctl_in.mode > AM_INDY) ? ST_IMPL : ST_OPLO;
            ST_IMPL: begin
                done = 1'b1;
                nxt  = ST_FETCH;
            end
            ST_OPLO: begin
                case (ctl.mode)
                    AM_ZP:                  nxt = ST_EFF;
                    AM_ZPX, AM_ZPY, AM_INDX: nxt = ST_ZIDX;
                    AM_INDY:                nxt = ST_PLO;
                    default:                nxt = ST_OPHI;
                endcase
            end
            ST_OPHI: nxt = (ctl.mode == AM_ABS) ? ST_EFF : ST_FIX;
            ST_ZIDX: nxt = (ctl.mode == AM_INDX) ? ST_PLO : ST_EFF;
            ST_PLO:  nxt = ST_PHI;
            ST_PHI:  nxt = (ctl.mode == AM_INDX) ? ST_EFF : ST_FIX;
            ST_FIX: begin
                // only plain reads may skip the fix-up cycle
                if (!(ctl.kind inside {AK_WRITE, AK_RMW}) && !fix_carry) begin
                    done = 1'b1;
                    nxt  = ST_FETCH;
                end else begin
                    nxt = ST_EFF;
                end
            end
            ST_EFF: begin
                if (ctl.kind == AK_RMW) begin
                    nxt = ST_KEEP;
                end else begin
                    done = 1'b1;
                    nxt  = ST_FETCH;
                end
            end
            ST_KEEP: nxt = ST_MOD;
            ST_MOD: begin
                done = 1'b1;
                nxt  = ST_FETCH;
            end
            default: nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/amode_agen.sv
`timescale 1ns/1ps
module amode_agen
    import amode_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  state_e        state,
    input  amode_e        mode,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic          fix_carry
);
    localparam logic [DW-1:0] ZPAGE = '0;

    logic [AW-1:0] pc_q, ea_q;
    logic [DW-1:0] ptr_q, idx, zsum, ptr_nx;
    logic [DW:0]   lo_sum;

    assign idx       = mode_uses_y(mode) ? y : x;
    assign lo_sum    = {1'b0, ea_q[DW-1:0]} + {1'b0, idx};
    assign zsum      = ptr_q + idx;        // wraps inside page zero
    assign ptr_nx    = ptr_q + 1'b1;       // wraps inside page zero
    assign fix_carry = lo_sum[DW];

    always_comb begin
        case (state)
            ST_FETCH, ST_IMPL, ST_OPLO, ST_OPHI: addr = pc_q;
            ST_ZIDX, ST_PLO:                     addr = {ZPAGE, ptr_q};
            ST_PHI:                              addr = {ZPAGE, ptr_nx};
            ST_FIX:                              addr = {ea_q[AW-1:DW], lo_sum[DW-1:0]};
            default:                             addr = ea_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= RESET_PC;
            ea_q  <= '0;
            ptr_q <= '0;
        end else begin
            case (state)
                ST_FETCH: pc_q <= pc_q + AW'(1);
                ST_OPLO: begin
                    pc_q  <= pc_q + AW'(1);
                    ptr_q <= rdata;
                    ea_q  <= {ZPAGE, rdata};
                end
                ST_OPHI: begin
                    pc_q           <= pc_q + AW'(1);
                    ea_q[AW-1:DW]  <= rdata;
                end
                ST_ZIDX: begin
                    ptr_q <= zsum;
                    ea_q  <= {ZPAGE, zsum};
                end
                ST_PLO: ea_q[DW-1:0]  <= rdata;
                ST_PHI: ea_q[AW-1:DW] <= rdata;
                ST_FIX: ea_q <= {ea_q[AW-1:DW] + DW'(lo_sum[DW]), lo_sum[DW-1:0]};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/amode_wdata.sv
`timescale 1ns/1ps
module amode_wdata
    import amode_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  state_e        state,
    input  akind_e        kind,
    input  mop_e          op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] rdata,
    output logic          we,
    output logic [DW-1:0] wdata
);
    logic [DW-1:0] opnd_q;

    always_ff @(posedge clk) begin
        if (rst)                  opnd_q <= '0;
        else if (state == ST_EFF) opnd_q <= rdata;
    end

    always_comb begin
        we    = 1'b0;
        wdata = '0;
        case (state)
            ST_EFF: begin
                if (kind == AK_WRITE) begin
                    we    = 1'b1;
                    wdata = acc;
                end
            end
            ST_KEEP: begin
                we    = 1'b1;
                wdata = opnd_q;
            end
            ST_MOD: begin
                we    = 1'b1;
                wdata = apply_mop(op, opnd_q);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/amode_bus_seq.sv
`timescale 1ns/1ps
module amode_bus_seq
    import amode_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  mode_i,
    input  logic [1:0]  kind_i,
    input  logic [1:0]  mop_i,
    input  logic [7:0]  x_i,
    input  logic [7:0]  y_i,
    input  logic [7:0]  acc_i,
    input  logic [7:0]  rdata_i,
    output logic [15:0] addr_o,
    output logic        we_o,
    output logic [7:0]  wdata_o,
    output logic        done_o
);
    ictl_t  ctl_in, ctl;
    state_e state;
    logic   fix_carry;
    mop_e   cur_mop;

    assign ctl_in.mode = amode_e'(mode_i);
    assign ctl_in.kind = akind_e'(kind_i);
    assign ctl_in.op   = mop_e'(mop_i);
    assign cur_mop     = ctl.op;

    amode_fsm u_fsm (
        .clk(clk), .rst(rst), .ctl_in(ctl_in), .fix_carry(fix_carry),
        .state(state), .ctl(ctl), .done(done_o)
    );

    amode_agen #(.RESET_PC(RESET_PC)) u_agen (
        .clk(clk), .rst(rst), .state(state), .mode(ctl.mode),
        .x(x_i), .y(y_i), .rdata(rdata_i), .addr(addr_o), .fix_carry(fix_carry)
    );

    amode_wdata u_wdata (
        .clk(clk), .rst(rst), .state(state), .kind(ctl.kind), .op(cur_mop),
        .acc(acc_i), .rdata(rdata_i), .we(we_o), .wdata(wdata_o)
    );
endmodule

// File: rtl/amode_bus_seq_chk.sv
`timescale 1ns/1ps
module amode_bus_seq_chk
    import amode_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [15:0] addr,
    input logic        we,
    input logic [7:0]  wdata,
    input logic        done,
    input logic [7:0]  rdata,
    input mop_e        op
);
    // R2: instructions last at least two cycles
    assert_done_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: the cycle after the last one is an opcode fetch, a read
    assert_fetch_after_done_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !we);

    // R11: unchanged write-back is followed by a write to the same address
    assert_rmw_same_addr_R11: assert property (@(posedge clk) disable iff (rst)
        (we && !done) |=> (we && done && $stable(addr)));

    // R11: the first write-back carries the value read the cycle before
    assert_rmw_keep_value_R11: assert property (@(posedge clk) disable iff (rst)
        (we && !done) |-> (wdata == $past(rdata)));

    // R12: the second write carries the modified form of the first
    assert_rmw_mod_value_R12: assert property (@(posedge clk) disable iff (rst)
        (we && $past(we) && !$past(done)) |-> (wdata == apply_mop(op, $past(wdata))));
endmodule

bind amode_bus_seq amode_bus_seq_chk u_chk (
    .clk(clk), .rst(rst), .addr(addr_o), .we(we_o), .wdata(wdata_o),
    .done(done_o), .rdata(rdata_i), .op(cur_mop)
);

// File: tb/amode_bus_seq_test.sv
`timescale 1ns/1ps
module amode_bus_seq_test;
    localparam logic [15:0] PC0 = 16'h0800;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [3:0]  mode_i = '0;
    logic [1:0]  kind_i = '0, mop_i = '0;
    logic [7:0]  x_i = '0, y_i = '0, acc_i = '0;
    logic [7:0]  rdata_i, wdata_o;
    logic [15:0] addr_o;
    logic        we_o, done_o;
    logic [7:0]  mem [0:4095];

    assign rdata_i = mem[addr_o[11:0]];

    amode_bus_seq #(.RESET_PC(PC0)) uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .kind_i(kind_i), .mop_i(mop_i),
        .x_i(x_i), .y_i(y_i), .acc_i(acc_i), .rdata_i(rdata_i),
        .addr_o(addr_o), .we_o(we_o), .wdata_o(wdata_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [15:0] a;
        logic        w;
        logic [7:0]  d;
        logic        dn;
    } bus_t;

    bus_t expq[$];
    int   vecs = 0;
    int   errs = 0;
    int   pc   = PC0;

    function automatic logic [7:0] rd(int a);
        return mem[a & 12'hFFF];
    endfunction

    function automatic logic [7:0] modv(int op, logic [7:0] v);
        if (op == 1) return {v[6:0], 1'b0};
        if (op == 2) return {1'b0, v[7:1]};
        return v + 8'd1;
    endfunction

    task automatic push(int a, bit w, logic [7:0] d, bit dn);
        bus_t e;
        e.a = a[15:0]; e.w = w; e.d = d; e.dn = dn;
        expq.push_back(e);
    endtask

    task automatic chk(string req, bit ok, string what, int act, int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_instr(string req, int mode, int kind, int op,
                             logic [7:0] b1, logic [7:0] b2,
                             logic [7:0] x, logic [7:0] y, logic [7:0] a, int ncyc);
        int idx, ea, base, p, part, full, n, k, dlen;
        bit ended;
        logic [7:0] v;
        bus_t e;
        expq.delete();
        mem[pc & 12'hFFF]       = 8'hEA;
        mem[(pc + 1) & 12'hFFF] = b1;
        mem[(pc + 2) & 12'hFFF] = b2;
        mode_i = mode[3:0]; kind_i = kind[1:0]; mop_i = op[1:0];
        x_i = x; y_i = y; acc_i = a;
        ended = 0; ea = 0; base = 0;
        push(pc, 0, 0, 0);
        if (mode == 0 || mode > 8) begin
            push(pc + 1, 0, 0, 1);
            n = 1;
            ended = 1;
        end else begin
            idx = (mode == 3 || mode == 6 || mode == 8) ? int'(y) : int'(x);
            push(pc + 1, 0, 0, 0);
            n = 2;
            case (mode)
                1: ea = b1;
                2, 3: begin push(b1, 0, 0, 0); ea = (b1 + idx) & 255; end
                4, 5, 6: begin push(pc + 2, 0, 0, 0); n = 3; base = {b2, b1}; ea = base; end
                7: begin
                    push(b1, 0, 0, 0);
                    p = (b1 + idx) & 255;
                    push(p, 0, 0, 0);
                    push((p + 1) & 255, 0, 0, 0);
                    ea = {rd((p + 1) & 255), rd(p)};
                end
                default: begin
                    push(b1, 0, 0, 0);
                    push((b1 + 1) & 255, 0, 0, 0);
                    base = {rd((b1 + 1) & 255), rd(b1)};
                end
            endcase
            if (mode == 5 || mode == 6 || mode == 8) begin
                part = (base & 16'hFF00) | ((base + idx) & 255);
                full = (base + idx) & 16'hFFFF;
                if (kind != 1 && kind != 2 && part == full) begin
                    push(full, 0, 0, 1);
                    ended = 1;
                end else begin
                    push(part, 0, 0, 0);
                    ea = full;
                end
            end
        end
        if (!ended) begin
            if (kind == 1) push(ea, 1, a, 1);
            else if (kind == 2) begin
                v = rd(ea);
                push(ea, 0, 0, 0);
                push(ea, 1, v, 0);
                push(ea, 1, modv(op, v), 1);
            end else push(ea, 0, 0, 1);
        end
        pc = (pc + n) & 16'hFFFF;
        k = 0;
        dlen = -1;
        while (expq.size() > 0) begin
            e = expq.pop_front();
            k++;
            chk(req, addr_o == e.a, "addr", addr_o, e.a);
            chk(req, we_o == e.w, "we", we_o, e.w);
            chk(req, done_o == e.dn, "done", done_o, e.dn);
            if (e.w) begin
                chk(req, wdata_o == e.d, "wdata", wdata_o, e.d);
                mem[e.a[11:0]] = e.d;
            end
            if (done_o && dlen < 0) dlen = k;
            @(negedge clk);
        end
        chk(req, dlen == ncyc, "cycle count", dlen, ncyc);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 7 + 3) & 255);
        mem[12'h049] = 8'h50; mem[12'h04A] = 8'h04;   // (zp,X) pointer
        mem[12'h0FF] = 8'h60; mem[12'h000] = 8'h04;   // pointer across page-zero top
        mem[12'h060] = 8'h20; mem[12'h061] = 8'h05;   // (zp),Y no carry
        mem[12'h062] = 8'hF8; mem[12'h063] = 8'h05;   // (zp),Y carry
        mem[12'h021] = 8'h7F;
        mem[12'h321] = 8'hFF;                          // INC wrap
        mem[12'h035] = 8'h81;                          // ASL bit 7 out
        mem[12'h036] = 8'h03;                          // LSR bit 0 out

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", addr_o == PC0, "reset addr", addr_o, PC0);
        chk("R1", we_o == 1'b0, "reset we", we_o, 0);
        chk("R1", done_o == 1'b0, "reset done", done_o, 0);
        rst = 1'b0;

        run_instr("R3",  0, 0, 0, 8'h00, 8'h00, 8'h05, 8'h10, 8'h3C, 2);
        run_instr("R3",  12, 0, 0, 8'h00, 8'h00, 8'h05, 8'h10, 8'h3C, 2);
        run_instr("R4",  1, 0, 0, 8'h20, 8'h00, 8'h05, 8'h10, 8'h3C, 3);
        run_instr("R4",  1, 1, 0, 8'h22, 8'h00, 8'h05, 8'h10, 8'h3C, 3);
        run_instr("R4",  2, 0, 0, 8'h20, 8'h00, 8'h05, 8'h10, 8'h3C, 4);
        run_instr("R4",  2, 0, 0, 8'hFE, 8'h00, 8'h05, 8'h10, 8'h3C, 4);
        run_instr("R4",  3, 1, 0, 8'h30, 8'h00, 8'h05, 8'h10, 8'hA5, 4);
        run_instr("R5",  4, 0, 0, 8'h45, 8'h03, 8'h05, 8'h10, 8'h3C, 4);
        run_instr("R10", 4, 1, 0, 8'h46, 8'h03, 8'h05, 8'h10, 8'h5A, 4);
        run_instr("R6",  5, 0, 0, 8'h10, 8'h03, 8'h05, 8'h10, 8'h3C, 4);
        run_instr("R6",  5, 0, 0, 8'hFE, 8'h03, 8'h05, 8'h10, 8'h3C, 5);
        run_instr("R6",  6, 3, 0, 8'hF8, 8'h03, 8'h05, 8'h10, 8'h3C, 5);
        run_instr("R7",  6, 1, 0, 8'h20, 8'h03, 8'h05, 8'h10, 8'h11, 5);
        run_instr("R7",  6, 1, 0, 8'hF8, 8'h03, 8'h05, 8'h10, 8'h22, 5);
        run_instr("R8",  7, 0, 0, 8'h44, 8'h00, 8'h05, 8'h10, 8'h3C, 6);
        run_instr("R8",  7, 1, 0, 8'hFC, 8'h00, 8'h03, 8'h10, 8'h33, 6);
        run_instr("R9",  8, 0, 0, 8'h60, 8'h00, 8'h05, 8'h10, 8'h3C, 5);
        run_instr("R9",  8, 0, 0, 8'h62, 8'h00, 8'h05, 8'h10, 8'h3C, 6);
        run_instr("R9",  8, 1, 0, 8'h60, 8'h00, 8'h05, 8'h10, 8'h44, 6);
        run_instr("R9",  8, 1, 0, 8'hFF, 8'h00, 8'h05, 8'h10, 8'h55, 6);
        run_instr("R11", 1, 2, 0, 8'h21, 8'h00, 8'h05, 8'h10, 8'h3C, 5);
        run_instr("R11", 2, 2, 0, 8'h1C, 8'h00, 8'h05, 8'h10, 8'h3C, 6);
        run_instr("R12", 4, 2, 0, 8'h21, 8'h03, 8'h05, 8'h10, 8'h3C, 6);
        run_instr("R11", 5, 2, 0, 8'h10, 8'h03, 8'h05, 8'h10, 8'h3C, 7);
        run_instr("R7",  5, 2, 3, 8'hFE, 8'h03, 8'h05, 8'h10, 8'h3C, 7);
        run_instr("R12", 2, 2, 1, 8'h30, 8'h00, 8'h05, 8'h10, 8'h3C, 6);
        run_instr("R12", 1, 2, 2, 8'h36, 8'h00, 8'h05, 8'h10, 8'h3C, 5);
        run_instr("R2",  0, 0, 0, 8'h00, 8'h00, 8'h05, 8'h10, 8'h3C, 2);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule